// File: doc/BRIEF.md
# Banked Legacy Interrupt Controller

This block gathers level-sensitive peripheral interrupt lines into banks of 32 and turns them into interrupt requests for two processor targets: a main CPU and a coprocessor. Each target has its own per-line enable mask and its own per-line class mask. The class mask sends an enabled, pending line either to the target's normal interrupt output or to its fast interrupt output. Software can also raise any line by setting a force bit. A line is pending when its synchronised input is high or its force bit is set.

Software reaches the registers over a simple 32-bit request bus. The address carries a bank field and an 8-bit register offset. The enable and force registers are never written directly. Each has one alias that sets the bits written as one and another that clears them, so a single access can touch any subset of lines without a read-modify-write. Each bank drives its own four output bits, one for each pair of target and class. Line n of the flat input vector belongs to bank n/32 at bit n mod 32.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, every enable, force and class bit is zero, every interrupt output is low, and reads of every register return zero.
- R2: A write to offset 0x24 sets the CPU enable bits that are one in the data. A write to 0x28 clears them. Bits written as zero keep their value. Offset 0x20 reads back the CPU enable mask.
- R3: A write to offset 0x18 sets force bits and a write to 0x1C clears them. Offset 0x14 reads the force mask. A set force bit makes its line pending with no external input.
- R4: Offset 0x2C is the CPU class mask, written and read directly. Class 0 routes an enabled pending line to the normal output and class 1 routes it to the fast output, never to both.
- R5: The coprocessor has its own enable mask, read at 0x30, set at 0x34 and cleared at 0x38, and its own class mask at 0x3C. Both are independent of the CPU masks.
- R6: Writing all ones to a clear alias (0x1C, 0x28 or 0x38) zeroes that whole 32-bit mask in one access.
- R7: Offset 0x08 reads, without side effects, the lines that are pending, CPU-enabled and of CPU class 1.
- R8: Each output is the OR over its bank of pending AND enabled AND matching class. It is registered, so it changes on the clock edge after the edge that updates the state.
- R9: External lines pass through a two-flop synchroniser. A change on an input line reaches the output on the third rising edge after it.
- R10: Line n drives bank n/32, bit n mod 32, and bank b is addressed with bus address bits [top:8] equal to b.
- R11: Reads of the set and clear alias offsets, of unmapped offsets and of banks at or above the bank count return zero. Writes to unmapped offsets or to missing banks change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_line_i | input | NUM_BANKS*32 | Level-sensitive peripheral lines, line n at bit n |
| bus_req_i | input | 1 | Bus access request, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | BANK_W+8 | Bank field in upper bits, register offset in bits [7:0] |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| cpu_irq_o | output | NUM_BANKS | CPU normal interrupt, one per bank |
| cpu_fiq_o | output | NUM_BANKS | CPU fast interrupt, one per bank |
| cop_irq_o | output | NUM_BANKS | Coprocessor normal interrupt, one per bank |
| cop_fiq_o | output | NUM_BANKS | Coprocessor fast interrupt, one per bank |

## Verification
The bench builds the block with the default six banks. This gives a three-bit bank field with two unused codes, so writes to bank 6 can be shown not to alias onto bank 2, and the highest line, 191, can be driven into the last bank. With six banks the bench can also run the coprocessor in one bank and the CPU in another, which shows the two targets and the banks are independent. The exact latencies of a force write and of the synchroniser are sampled on the cycles where they must first appear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned LINES = 32;

  typedef logic [LINES-1:0] line_vec_t;

  localparam logic [7:0] OFF_FIQ_STAT   = 8'h08;
  localparam logic [7:0] OFF_FRC        = 8'h14;
  localparam logic [7:0] OFF_FRC_SET    = 8'h18;
  localparam logic [7:0] OFF_FRC_CLR    = 8'h1C;
  localparam logic [7:0] OFF_CPU_EN     = 8'h20;
  localparam logic [7:0] OFF_CPU_EN_SET = 8'h24;
  localparam logic [7:0] OFF_CPU_EN_CLR = 8'h28;
  localparam logic [7:0] OFF_CPU_CLS    = 8'h2C;
  localparam logic [7:0] OFF_COP_EN     = 8'h30;
  localparam logic [7:0] OFF_COP_EN_SET = 8'h34;
  localparam logic [7:0] OFF_COP_EN_CLR = 8'h38;
  localparam logic [7:0] OFF_COP_CLS    = 8'h3C;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [7:0]  off_i,
  input  logic [31:0] wdata_i,
  input  line_vec_t   line_i,
  output logic [31:0] rdata_o,
  output logic        cpu_irq_o,
  output logic        cpu_fiq_o,
  output logic        cop_irq_o,
  output logic        cop_fiq_o
);

  line_vec_t cpu_en_q, cpu_en_d;
  line_vec_t cpu_cls_q, cpu_cls_d;
  line_vec_t cop_en_q, cop_en_d;
  line_vec_t cop_cls_q, cop_cls_d;
  line_vec_t frc_q, frc_d;
  line_vec_t pend;
  logic cpu_irq_q, cpu_fiq_q, cop_irq_q, cop_fiq_q;
  logic cpu_irq_d, cpu_fiq_d, cop_irq_d, cop_fiq_d;

  always_comb begin
    cpu_en_d  = cpu_en_q;
    cpu_cls_d = cpu_cls_q;
    cop_en_d  = cop_en_q;
    cop_cls_d = cop_cls_q;
    frc_d     = frc_q;
    unique case (off_i)
      OFF_FRC_SET:    frc_d     = frc_q | wdata_i;
      OFF_FRC_CLR:    frc_d     = frc_q & ~wdata_i;
      OFF_CPU_EN_SET: cpu_en_d  = cpu_en_q | wdata_i;
      OFF_CPU_EN_CLR: cpu_en_d  = cpu_en_q & ~wdata_i;
      OFF_CPU_CLS:    cpu_cls_d = wdata_i;
      OFF_COP_EN_SET: cop_en_d  = cop_en_q | wdata_i;
      OFF_COP_EN_CLR: cop_en_d  = cop_en_q & ~wdata_i;
      OFF_COP_CLS:    cop_cls_d = wdata_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_en_q  <= '0;
      cpu_cls_q <= '0;
      cop_en_q  <= '0;
      cop_cls_q <= '0;
      frc_q     <= '0;
    end else if (wr_i) begin
      cpu_en_q  <= cpu_en_d;
      cpu_cls_q <= cpu_cls_d;
      cop_en_q  <= cop_en_d;
      cop_cls_q <= cop_cls_d;
      frc_q     <= frc_d;
    end
  end

  assign pend = line_i | frc_q;

  always_comb begin
    cpu_irq_d = |(pend & cpu_en_q & ~cpu_cls_q);
    cpu_fiq_d = |(pend & cpu_en_q &  cpu_cls_q);
    cop_irq_d = |(pend & cop_en_q & ~cop_cls_q);
    cop_fiq_d = |(pend & cop_en_q &  cop_cls_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_irq_q <= 1'b0;
      cpu_fiq_q <= 1'b0;
      cop_irq_q <= 1'b0;
      cop_fiq_q <= 1'b0;
    end else begin
      cpu_irq_q <= cpu_irq_d;
      cpu_fiq_q <= cpu_fiq_d;
      cop_irq_q <= cop_irq_d;
      cop_fiq_q <= cop_fiq_d;
    end
  end

  assign cpu_irq_o = cpu_irq_q;
  assign cpu_fiq_o = cpu_fiq_q;
  assign cop_irq_o = cop_irq_q;
  assign cop_fiq_o = cop_fiq_q;

  always_comb begin
    unique case (off_i)
      OFF_FIQ_STAT: rdata_o = pend & cpu_en_q & cpu_cls_q;
      OFF_FRC:      rdata_o = frc_q;
      OFF_CPU_EN:   rdata_o = cpu_en_q;
      OFF_CPU_CLS:  rdata_o = cpu_cls_q;
      OFF_COP_EN:   rdata_o = cop_en_q;
      OFF_COP_CLS:  rdata_o = cop_cls_q;
      default:      rdata_o = '0;
    endcase
  end

  // R2: bits written to the set alias are all present afterwards
  p_set_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && off_i == OFF_CPU_EN_SET) |=>
      ((cpu_en_q & $past(wdata_i)) == $past(wdata_i)));

  // R6: an all-ones clear empties the mask in one access
  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && off_i == OFF_CPU_EN_CLR && wdata_i == '1) |=> (cpu_en_q == '0));

  p_cop_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && off_i == OFF_COP_EN_CLR && wdata_i == '1) |=> (cop_en_q == '0));

  // R8: with nothing enabled, no CPU output can be raised
  p_no_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_en_q) == '0) |-> (!cpu_irq_q && !cpu_fiq_q));

  // R4: all lines of class 1 keep the normal output low
  p_class_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_cls_q) == '1) |-> !cpu_irq_q);

  // R11: writes to unmapped offsets leave every mask unchanged
  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && off_i == 8'h40) |=>
      ($stable(cpu_en_q) && $stable(frc_q) && $stable(cop_en_q) &&
       $stable(cpu_cls_q) && $stable(cop_cls_q)));

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 6,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned ADDR_W   = BANK_W + 8,
  localparam int unsigned NLINES   = NUM_BANKS * LINES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NLINES-1:0]     irq_line_i,
  input  logic                  bus_req_i,
  input  logic                  bus_wr_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [31:0]           bus_wdata_i,
  output logic [31:0]           bus_rdata_o,
  output logic [NUM_BANKS-1:0]  cpu_irq_o,
  output logic [NUM_BANKS-1:0]  cpu_fiq_o,
  output logic [NUM_BANKS-1:0]  cop_irq_o,
  output logic [NUM_BANKS-1:0]  cop_fiq_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  logic [NLINES-1:0]    line_sync;
  logic [BANK_W-1:0]    bank_idx;
  logic [7:0]           reg_off;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [31:0]          bank_rd [NUM_BANKS];
  logic [31:0]          rdata_d, rdata_q;

  assign bank_idx = bus_addr_i[ADDR_W-1:8];
  assign reg_off  = bus_addr_i[7:0];

  irqc_sync #(.W(NLINES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .async_i (irq_line_i),
    .sync_o  (line_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_hit[b] = bus_req_i && (bank_idx == BANK_W'(b));

    irqc_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .wr_i      (bank_hit[b] && bus_wr_i),
      .off_i     (reg_off),
      .wdata_i   (bus_wdata_i),
      .line_i    (line_sync[b*LINES +: LINES]),
      .rdata_o   (bank_rd[b]),
      .cpu_irq_o (cpu_irq_o[b]),
      .cpu_fiq_o (cpu_fiq_o[b]),
      .cop_irq_o (cop_irq_o[b]),
      .cop_fiq_o (cop_fiq_o[b])
    );
  end

  always_comb begin
    rdata_d = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      rdata_d = rdata_d | (bank_rd[b] & {32{bank_hit[b] && !bus_wr_i}});
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;

  // R11: alias offsets read as zero
  p_alias_zero_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_req_i && !bus_wr_i &&
     (reg_off == OFF_CPU_EN_SET || reg_off == OFF_CPU_EN_CLR ||
      reg_off == OFF_FRC_SET || reg_off == OFF_FRC_CLR ||
      reg_off == OFF_COP_EN_SET || reg_off == OFF_COP_EN_CLR))
    |=> (bus_rdata_o == '0));

  // R11: a missing bank reads as zero
  p_bad_bank_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_req_i && !bus_wr_i && (int'(bank_idx) >= NUM_BANKS))
    |=> (bus_rdata_o == '0));

  // R1: no read request, no read data
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_req_i |=> (bus_rdata_o == '0));

endmodule

// File: tb/sim_banked_irq_ctrl.sv
module sim_banked_irq_ctrl;
  localparam int NB = 6;
  localparam int AW = 11;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NB*32-1:0] irq_line;
  logic            req, wr;
  logic [AW-1:0]   addr;
  logic [31:0]     wdata;
  logic [31:0]     rdata;
  logic [NB-1:0]   cpu_irq, cpu_fiq, cop_irq, cop_fiq;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  banked_irq_ctrl #(.NUM_BANKS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_line_i(irq_line),
    .bus_req_i(req), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .cpu_irq_o(cpu_irq), .cpu_fiq_o(cpu_fiq),
    .cop_irq_o(cop_irq), .cop_fiq_o(cop_fiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int bank, input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = {bank[2:0], off}; wdata = d;
    @(negedge clk);
    req = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input int bank, input logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b0; addr = {bank[2:0], off};
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int bank, input logic [7:0] off, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(bank, off, v);
    chk(tag, v, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 cpu_irq", {26'b0, cpu_irq}, 32'h0);
    chk("R1 outs", {8'b0, cpu_fiq, cop_irq, cop_fiq}, 32'h0);
    rd_chk("R1 cpu_en", 0, 8'h20, 32'h0);
    rd_chk("R1 force", 0, 8'h14, 32'h0);
    rd_chk("R1 cpu_cls", 0, 8'h2C, 32'h0);
    rd_chk("R1 cop_en", 5, 8'h30, 32'h0);
    rd_chk("R1 cop_cls", 5, 8'h3C, 32'h0);
  endtask

  task automatic t_cpu_enable;
    bus_wr(0, 8'h24, 32'h0000_00F0);
    rd_chk("R2 set", 0, 8'h20, 32'h0000_00F0);
    bus_wr(0, 8'h24, 32'h0000_000F);
    rd_chk("R2 set keeps", 0, 8'h20, 32'h0000_00FF);
    bus_wr(0, 8'h28, 32'h0000_0030);
    rd_chk("R2 clear", 0, 8'h20, 32'h0000_00CF);
    bus_wr(0, 8'h24, 32'h0);
    bus_wr(0, 8'h28, 32'h0);
    rd_chk("R2 zero write", 0, 8'h20, 32'h0000_00CF);
  endtask

  task automatic t_force;
    bus_wr(0, 8'h18, 32'h1);
    chk("R8 one cycle after write", {31'b0, cpu_irq[0]}, 32'h0);
    @(negedge clk);
    chk("R3 force raises irq", {31'b0, cpu_irq[0]}, 32'h1);
    rd_chk("R3 force read", 0, 8'h14, 32'h1);
    bus_wr(0, 8'h1C, 32'h1);
    idle(1);
    chk("R3 force retired", {31'b0, cpu_irq[0]}, 32'h0);
    rd_chk("R3 force cleared", 0, 8'h14, 32'h0);
  endtask

  task automatic t_class;
    bus_wr(0, 8'h2C, 32'h1);
    bus_wr(0, 8'h18, 32'h1);
    idle(1);
    chk("R4 fiq high", {31'b0, cpu_fiq[0]}, 32'h1);
    chk("R4 irq low", {31'b0, cpu_irq[0]}, 32'h0);
    rd_chk("R7 status set", 0, 8'h08, 32'h1);
    rd_chk("R4 class read", 0, 8'h2C, 32'h1);
    bus_wr(0, 8'h2C, 32'h0);
    idle(1);
    chk("R4 irq high", {31'b0, cpu_irq[0]}, 32'h1);
    chk("R4 fiq low", {31'b0, cpu_fiq[0]}, 32'h0);
    rd_chk("R7 status clear", 0, 8'h08, 32'h0);
    bus_wr(0, 8'h1C, 32'hFFFF_FFFF);
  endtask

  task automatic t_cop;
    bus_wr(2, 8'h34, 32'h8);
    rd_chk("R5 cop en", 2, 8'h30, 32'h8);
    rd_chk("R5 cpu en untouched", 2, 8'h20, 32'h0);
    bus_wr(2, 8'h18, 32'h8);
    idle(1);
    chk("R5 cop irq", {28'b0, cop_irq[2], cop_fiq[2], cpu_irq[2], cpu_fiq[2]}, 32'h8);
    bus_wr(2, 8'h3C, 32'h8);
    idle(1);
    chk("R5 cop fiq", {28'b0, cop_irq[2], cop_fiq[2], cpu_irq[2], cpu_fiq[2]}, 32'h4);
    rd_chk("R5 cop cls", 2, 8'h3C, 32'h8);
    rd_chk("R7 cop class not in status", 2, 8'h08, 32'h0);
    bus_wr(2, 8'h38, 32'h8);
    idle(1);
    chk("R5 cop cleared", {30'b0, cop_irq[2], cop_fiq[2]}, 32'h0);
    bus_wr(2, 8'h1C, 32'h8);
    bus_wr(2, 8'h3C, 32'h0);
  endtask

  task automatic t_clear_all;
    bus_wr(3, 8'h24, 32'hFFFF_FFFF);
    bus_wr(3, 8'h34, 32'hFFFF_FFFF);
    bus_wr(3, 8'h18, 32'hFFFF_FFFF);
    rd_chk("R6 full set", 3, 8'h20, 32'hFFFF_FFFF);
    bus_wr(3, 8'h28, 32'hFFFF_FFFF);
    rd_chk("R6 cpu cleared", 3, 8'h20, 32'h0);
    bus_wr(3, 8'h38, 32'hFFFF_FFFF);
    rd_chk("R6 cop cleared", 3, 8'h30, 32'h0);
    bus_wr(3, 8'h1C, 32'hFFFF_FFFF);
    rd_chk("R6 force cleared", 3, 8'h14, 32'h0);
  endtask

  task automatic t_sync;
    bus_wr(1, 8'h24, 32'h20);
    @(negedge clk);
    irq_line[37] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 not yet after two edges", {31'b0, cpu_irq[1]}, 32'h0);
    @(negedge clk);
    chk("R9 on third edge", {31'b0, cpu_irq[1]}, 32'h1);
    chk("R10 line 37 only bank 1", {26'b0, cpu_irq}, 32'h2);
    bus_wr(1, 8'h2C, 32'h20);
    rd_chk("R7 status from line", 1, 8'h08, 32'h20);
    bus_wr(1, 8'h2C, 32'h0);
    irq_line[37] = 1'b0;
    idle(4);
    chk("R9 line released", {26'b0, cpu_irq}, 32'h0);
    bus_wr(5, 8'h24, 32'h8000_0000);
    irq_line[191] = 1'b1;
    idle(4);
    chk("R10 line 191 bank 5", {26'b0, cpu_irq}, 32'h20);
    irq_line[191] = 1'b0;
    idle(4);
  endtask

  task automatic t_unmapped;
    rd_chk("R11 set alias reads 0", 1, 8'h24, 32'h0);
    rd_chk("R11 clear alias reads 0", 0, 8'h28, 32'h0);
    bus_wr(1, 8'h18, 32'h1);
    rd_chk("R11 force alias reads 0", 1, 8'h18, 32'h0);
    bus_wr(1, 8'h1C, 32'h1);
    bus_wr(1, 8'h40, 32'hFFFF_FFFF);
    rd_chk("R11 unmapped write en", 1, 8'h20, 32'h20);
    rd_chk("R11 unmapped write cls", 1, 8'h2C, 32'h0);
    rd_chk("R11 unmapped read", 1, 8'h40, 32'h0);
    bus_wr(6, 8'h24, 32'hFFFF_FFFF);
    bus_wr(7, 8'h34, 32'hFFFF_FFFF);
    rd_chk("R11 bank 6 no alias bank 2", 2, 8'h20, 32'h0);
    rd_chk("R11 bank 7 no alias bank 3", 3, 8'h30, 32'h0);
    rd_chk("R11 bank 5 intact", 5, 8'h20, 32'h8000_0000);
    rd_chk("R11 missing bank reads 0", 6, 8'h20, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_line = '0; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_cpu_enable();
    t_force();
    t_class();
    t_cop();
    t_clear_all();
    t_sync();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule